// File: doc/BRIEF.md
# Output Stream Diagnostic Checksum

This block watches a 16-bit output sample stream and folds every accepted word into an 8-bit running signature. A diagnostic sync pulse closes the current frame: the signature gathered so far is captured into a read-only register and the running value starts again from zero. Software reads the captured value through a small register read port and compares it with an expected signature, so that each frame of the output bus can be checked without capturing the data itself.

The stream input follows valid/ready rules, but the block never applies back-pressure. `smp_ready` is held high whenever the block is out of reset, so a word transfers in every cycle where `smp_valid` is high. A producer may raise or drop `smp_valid` in any cycle. The data width must be a whole multiple of the checksum width.

Top module: `diag_checksum`

## Requirements
- R1: Out of reset, `smp_ready` is 1 in every cycle, and every cycle with `smp_valid` high transfers one word.
- R2: When a word transfers in a cycle without a sync, the running value becomes ((running + data[7:0] + data[15:8]) mod 256) rotated left by one bit.
- R3: When `diag_sync` is high, the captured register takes the running value as it stood before that cycle's word.
- R4: A sync without a word clears the running value to 0. A sync with a word sets it to (data[7:0] + data[15:8]) mod 256 rotated left by one bit, so that word opens the new frame.
- R5: The captured register keeps its value in every cycle without a sync.
- R6: A read strobe with `host_addr` equal to 15 returns the captured register on `host_rdata` in the next cycle, and `host_rdata` stays there until the next read.
- R7: A read strobe at any other address returns 0 on `host_rdata` in the next cycle.
- R8: Host writes, at address 15 or any other address, change neither the captured register nor the running value.
- R9: After reset, the running value, the captured register and `host_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Output word present |
| smp_ready | output | 1 | Word accepted (always high out of reset) |
| smp_data | input | 16 | Output sample word |
| diag_sync | input | 1 | Diagnostic frame sync pulse |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe (no effect) |
| host_addr | input | 6 | Register address |
| host_wdata | input | 8 | Write data (no effect) |
| host_rdata | output | 8 | Read data, one cycle after the strobe |

## Verification
The bench builds the block with its default parameters: a 16-bit word folded as two byte lanes into an 8-bit signature, with a 6-bit address and the register at 15. At these values every lane sum can carry past 8 bits and every rotation moves the top bit into bit 0, so directed words such as 0xFFFF and 0x8080 reach the wrap-around and carry corners. A reference model follows the stream cycle by cycle and is compared on every clock. It covers syncs with and without a word, back-to-back syncs, writes at the register address, and reads at other addresses, in both directed and random order.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic [1:0] {
    ACC_HOLD    = 2'd0,
    ACC_ADD     = 2'd1,
    ACC_CLEAR   = 2'd2,
    ACC_RESTART = 2'd3
  } acc_op_e;

  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_SUM_W    = 8;
  localparam int unsigned DEF_ADDR_W   = 6;
  localparam int unsigned DEF_REG_ADDR = 15;
endpackage

// File: rtl/csum_accum.sv
module csum_accum
  import csum_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SUM_W  = DEF_SUM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sync,
  input  logic [DATA_W-1:0] data,
  output logic [SUM_W-1:0]  run
);
  localparam int unsigned LANES = DATA_W / SUM_W;

  acc_op_e          op;
  logic [SUM_W-1:0] base;
  logic [SUM_W-1:0] lane_sum;
  logic [SUM_W-1:0] rotated;

  always_comb begin
    unique case ({sync, take})
      2'b00:   op = ACC_HOLD;
      2'b01:   op = ACC_ADD;
      2'b10:   op = ACC_CLEAR;
      default: op = ACC_RESTART;
    endcase
  end

  // a restart drops the old frame's running value from the sum
  assign base = (op == ACC_RESTART) ? '0 : run;

  always_comb begin
    lane_sum = base;
    for (int i = 0; i < LANES; i++) begin
      lane_sum = lane_sum + data[i*SUM_W +: SUM_W];
    end
  end

  assign rotated = {lane_sum[SUM_W-2:0], lane_sum[SUM_W-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
    end else begin
      unique case (op)
        ACC_ADD, ACC_RESTART: run <= rotated;
        ACC_CLEAR:            run <= '0;
        default:              run <= run;
      endcase
    end
  end

  assert_clear_on_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !take) |=> (run == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !take) |=> $stable(run));
endmodule

// File: rtl/csum_latch.sv
module csum_latch #(
  parameter int unsigned SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic [SUM_W-1:0] run_in,
  output logic [SUM_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (sync) held <= run_in;
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (held == $past(run_in)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(held));
endmodule

// File: rtl/csum_rdport.sv
module csum_rdport #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned SUM_W    = 8,
  parameter int unsigned REG_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SUM_W-1:0]  held,
  output logic [SUM_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(REG_ADDR);

  logic hit;
  assign hit = (addr == HIT);

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= hit ? held : '0;
  end

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (rdata == '0));

  assert_hit_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit) |=> (rdata == $past(held)));

  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/diag_checksum.sv
module diag_checksum
  import csum_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned SUM_W    = DEF_SUM_W,
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned REG_ADDR = DEF_REG_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              diag_sync,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [SUM_W-1:0]  host_wdata,
  output logic [SUM_W-1:0]  host_rdata
);
  logic [SUM_W-1:0] run;
  logic [SUM_W-1:0] held;
  logic             take;

  // never back-pressures; ready only drops in reset
  assign smp_ready = rst_n;
  assign take      = smp_valid & smp_ready;

  csum_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .sync(diag_sync),
    .data(smp_data), .run(run)
  );

  csum_latch #(.SUM_W(SUM_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .sync(diag_sync), .run_in(run), .held(held)
  );

  csum_rdport #(.ADDR_W(ADDR_W), .SUM_W(SUM_W), .REG_ADDR(REG_ADDR)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(host_rd), .addr(host_addr),
    .held(held), .rdata(host_rdata)
  );

  assert_always_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);

  assert_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !diag_sync && (host_wdata != held)) |=> $stable(held));
endmodule

// File: tb/diag_checksum_test.sv
module diag_checksum_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        diag_sync = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  int m_run = 0;
  int m_lat = 0;
  int m_rd = 0;

  always #4 clk = ~clk;

  diag_checksum uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .diag_sync(diag_sync), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  function automatic int fold(int acc, int w);
    int s;
    s = (acc + (w & 255) + ((w >> 8) & 255)) & 255;
    return ((s << 1) | (s >> 7)) & 255;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // one clock: drive, let the edge pass, advance model, compare
  task automatic cyc(bit v, int d, bit s, bit rd, bit wr, int a, int wd, string tag);
    smp_valid = v; smp_data = 16'(d); diag_sync = s;
    host_rd = rd; host_wr = wr; host_addr = 6'(a); host_wdata = 8'(wd);
    @(posedge clk);
    if (rd) m_rd = (a == 15) ? m_lat : 0;
    if (s) begin
      m_lat = m_run;
      m_run = v ? fold(0, d) : 0;
    end else if (v) begin
      m_run = fold(m_run, d);
    end
    cycles++;
    @(negedge clk);
    check({tag, " R1 ready"}, int'(smp_ready), 1);
    check(tag, int'(host_rdata), m_rd);
  endtask

  task automatic read_reg(string tag);
    cyc(0, 0, 0, 1, 0, 15, 0, tag);
  endtask

  task automatic flush_probe(string tag);
    cyc(0, 0, 1, 0, 0, 0, 0, tag);
    read_reg(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rdata reset", int'(host_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    read_reg("R9 latched zero");
    flush_probe("R9 running zero");

    cyc(1, 16'h1234, 0, 0, 0, 0, 0, "R2 word");
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 0, "R2 carry");
    cyc(0, 16'hAAAA, 0, 0, 0, 0, 0, "R1 no valid ignored");
    cyc(1, 16'h8080, 0, 0, 0, 0, 0, "R2 rotate top bit");
    flush_probe("R3 capture");
    read_reg("R5 hold");
    flush_probe("R4 cleared after sync");

    cyc(1, 16'h0102, 0, 0, 0, 0, 0, "R2 prefix");
    cyc(1, 16'h7F01, 1, 0, 0, 0, 0, "R4 sync with word");
    read_reg("R3 excludes word");
    flush_probe("R4 word opens frame");

    cyc(1, 16'h5A5A, 0, 0, 0, 0, 0, "R2 word");
    flush_probe("R3 capture again");
    cyc(0, 0, 0, 0, 1, 15, 8'hC3, "R8 write at reg");
    cyc(0, 0, 0, 0, 1, 3, 8'h3C, "R8 write elsewhere");
    read_reg("R8 latched unchanged");
    cyc(0, 0, 0, 1, 0, 3, 0, "R7 other address");
    cyc(0, 0, 0, 1, 0, 63, 0, "R7 top address");
    cyc(0, 0, 0, 0, 0, 0, 0, "R6 rdata holds");

    cyc(1, 16'h00FF, 0, 0, 1, 15, 8'h11, "R8 write during stream");
    flush_probe("R8 running unchanged by write");
    cyc(0, 0, 1, 0, 0, 0, 0, "R4 back to back sync");
    read_reg("R4 back to back sync");

    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc(r < 70, int'($urandom_range(0, 65535)), r % 13 == 0,
          r % 5 == 0, r % 7 == 0, (r % 3 == 0) ? 15 : r % 64,
          int'($urandom_range(0, 255)), "R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule